// File: doc/BRIEF.md
# Branch Direction Predictor

This block supplies a taken or not-taken guess for a conditional branch while the fetch unit is still in its second stage. The guess is combinational from the lookup inputs. A mode input picks one of two policies. In the fixed policy, the sign of the branch displacement decides the guess: a backward branch is guessed taken. In the learned policy, a direct-mapped history table indexed by word-address bits of the branch PC decides it.

Once a branch resolves, its real outcome is written back into the table through an update port. A separate resolve port reports when a guess was wrong. The block then raises a redirect for a fixed number of bubble cycles and shows the bubbles still remaining. Reset, or a clear request, sweeps the table to zero one entry per cycle. A busy flag stays high during the sweep.

By default each entry is one bit. A parameter can instead select 2-bit saturating counters, and the table depth is also a parameter.

Top module: `bdir_predictor`

## Requirements
- R1: With `lk_dyn` = 0, `pred_taken` equals bit 20 (the sign bit) of `lk_disp`: 1 (backward) gives taken, 0 gives not taken.
- R2: With `lk_dyn` = 1 and `busy` = 0, `pred_taken` is the MSB of the table entry indexed by `lk_pc[12:2]` (default depth 2048). The PC bits outside that range have no effect.
- R3: In the 1-bit configuration, an update (`upd_valid` = 1) overwrites the entry at `upd_pc[12:2]` with `upd_taken`.
- R4: A lookup of an index in the same cycle as an update to that index returns the old entry. The new value is visible from the next cycle.
- R5: After reset is released, or after a one-cycle `clr_req`, `busy` is 1 for exactly DEPTH cycles (2048 by default; 4096 with 12 index bits) and every entry becomes 0. While `busy` is 1, learned-mode lookups give not taken and updates are ignored.
- R6: A cycle with `res_valid` = 1 and `res_mispredict` = 1 makes `bubble_cnt` read 4, 3, 2, 1 on the following four cycles and then 0. `redirect` is 1 exactly while `bubble_cnt` is non-zero. `res_valid` with `res_mispredict` = 0 starts nothing.
- R7: A mispredict reported while a redirect is already running reloads `bubble_cnt` to 4 on the next cycle.
- R8: In the 2-bit configuration, an update with taken = 1 increments the counter and one with taken = 0 decrements it. The counter saturates at 3 and at 0, and the guess is the counter MSB.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; starts a table sweep |
| clr_req | input | 1 | Restart the table sweep |
| lk_pc | input | 32 | PC of the branch being looked up |
| lk_disp | input | 21 | Displacement field of that branch |
| lk_dyn | input | 1 | 1 = learned (table) policy, 0 = displacement-sign policy |
| pred_taken | output | 1 | Guessed direction |
| upd_valid | input | 1 | Write a resolved outcome into the table |
| upd_pc | input | 32 | PC of the resolved branch |
| upd_taken | input | 1 | Resolved direction |
| res_valid | input | 1 | A resolution is being reported |
| res_mispredict | input | 1 | The reported guess was wrong |
| busy | output | 1 | Table sweep in progress |
| redirect | output | 1 | Redirect / bubble window active |
| bubble_cnt | output | 3 | Bubble cycles remaining |

## Verification
The assertions assume that update and resolve inputs are 0 or 1 at each clock edge. They also assume that read-after-write visibility is only asked for when no sweep is running at either of the two edges. The stimulus changes every input one time unit after a rising edge and holds it for the whole cycle. Updates during a sweep are issued only for indices the sweep has already passed, so any effect they had would stay in the table. The 2-bit instance receives the same inputs as the default one, on PCs the other checks do not reuse.

// File: rtl/bdp_pkg.sv
package bdp_pkg;

    typedef enum logic {
        POLICY_SIGN  = 1'b0,
        POLICY_TABLE = 1'b1
    } policy_e;

    typedef struct packed {
        logic en;
        logic taken;
    } outcome_t;

    localparam int SAT_W = 8;

    // step a saturating counter up or down within [0, top]
    function automatic logic [SAT_W-1:0] sat_step(input logic [SAT_W-1:0] cur,
                                                  input logic [SAT_W-1:0] top,
                                                  input logic up);
        logic [SAT_W-1:0] r;
        if (up) r = (cur == top) ? cur : cur + 1'b1;
        else    r = (cur == '0)  ? cur : cur - 1'b1;
        return r;
    endfunction

endpackage

// File: rtl/bdp_table.sv
module bdp_table
    import bdp_pkg::*;
#(
    parameter int IDX_W = 11,
    parameter int CTR_W = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr_req,
    input  logic [IDX_W-1:0] rd_idx,
    input  logic [IDX_W-1:0] wr_idx,
    input  outcome_t         wr,
    output logic             rd_hint,
    output logic             busy
);
    localparam int DEPTH = 1 << IDX_W;
    localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);
    localparam logic [CTR_W-1:0] CTR_TOP = {CTR_W{1'b1}};

    logic [CTR_W-1:0] mem [DEPTH];
    logic [IDX_W-1:0] sweep_idx;
    logic [CTR_W-1:0] next_val;
    logic [CTR_W-1:0] cur_val;

    assign cur_val = mem[wr_idx];

    generate
        if (CTR_W == 1) begin : g_bit
            assign next_val = wr.taken;
        end else begin : g_ctr
            assign next_val = CTR_W'(sat_step(SAT_W'(cur_val), SAT_W'(CTR_TOP), wr.taken));
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst || clr_req) begin
            busy      <= 1'b1;
            sweep_idx <= '0;
        end else if (busy) begin
            sweep_idx <= sweep_idx + 1'b1;
            if (sweep_idx == LAST) busy <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (busy)        mem[sweep_idx] <= '0;
        else if (wr.en)  mem[wr_idx]    <= next_val;
    end

    assign rd_hint = busy ? 1'b0 : mem[rd_idx][CTR_W-1];

    // R5
    sweep_end_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && !clr_req && sweep_idx == LAST) |=> !busy);

    // R5
    clear_start_chk: assert property (@(posedge clk) disable iff (rst)
        clr_req |=> (busy && sweep_idx == '0));

    generate
        if (CTR_W == 1) begin : g_rw_chk
            // R3 R4
            write_visible_chk: assert property (@(posedge clk) disable iff (rst)
                ($past(wr.en) && !$past(busy) && !$past(rst) && !busy && rd_idx == $past(wr_idx))
                    |-> rd_hint == $past(wr.taken));
        end
    endgenerate

endmodule

// File: rtl/bdp_redirect.sv
module bdp_redirect #(
    parameter int PENALTY = 4,
    parameter int CNT_W   = $clog2(PENALTY + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             miss,
    output logic             redirect,
    output logic [CNT_W-1:0] bubbles
);
    localparam logic [CNT_W-1:0] LOAD = CNT_W'(PENALTY);

    always_ff @(posedge clk) begin
        if (rst)               bubbles <= '0;
        else if (miss)         bubbles <= LOAD;
        else if (bubbles != 0) bubbles <= bubbles - 1'b1;
    end

    assign redirect = (bubbles != '0);

    // R6 R7
    penalty_load_chk: assert property (@(posedge clk) disable iff (rst)
        miss |=> (bubbles == LOAD && redirect));

    // R6
    penalty_count_chk: assert property (@(posedge clk) disable iff (rst)
        (!miss && redirect) |=> (bubbles == $past(bubbles) - 1'b1));

    // R6
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!miss && !redirect) |=> !redirect);

endmodule

// File: rtl/bdir_predictor.sv
module bdir_predictor
    import bdp_pkg::*;
#(
    parameter int PC_W    = 32,
    parameter int DISP_W  = 21,
    parameter int IDX_W   = 11,
    parameter int CTR_W   = 1,
    parameter int PENALTY = 4,
    parameter int CNT_W   = $clog2(PENALTY + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr_req,
    input  logic [PC_W-1:0]   lk_pc,
    input  logic [DISP_W-1:0] lk_disp,
    input  logic              lk_dyn,
    output logic              pred_taken,
    input  logic              upd_valid,
    input  logic [PC_W-1:0]   upd_pc,
    input  logic              upd_taken,
    input  logic              res_valid,
    input  logic              res_mispredict,
    output logic              busy,
    output logic              redirect,
    output logic [CNT_W-1:0]  bubble_cnt
);
    localparam int IDX_LO = 2;
    localparam int IDX_HI = IDX_LO + IDX_W - 1;

    logic [IDX_W-1:0] rd_idx;
    logic [IDX_W-1:0] wr_idx;
    outcome_t         wr;
    logic             hint;
    policy_e          policy;
    logic             unused_bits;

    assign rd_idx = lk_pc[IDX_HI:IDX_LO];
    assign wr_idx = upd_pc[IDX_HI:IDX_LO];
    assign wr     = '{en: upd_valid, taken: upd_taken};
    assign policy = policy_e'(lk_dyn);
    assign unused_bits = ^{lk_pc, upd_pc, lk_disp[DISP_W-2:0]};

    bdp_table #(.IDX_W(IDX_W), .CTR_W(CTR_W)) u_table (
        .clk     (clk),
        .rst     (rst),
        .clr_req (clr_req),
        .rd_idx  (rd_idx),
        .wr_idx  (wr_idx),
        .wr      (wr),
        .rd_hint (hint),
        .busy    (busy)
    );

    bdp_redirect #(.PENALTY(PENALTY), .CNT_W(CNT_W)) u_redirect (
        .clk      (clk),
        .rst      (rst),
        .miss     (res_valid && res_mispredict),
        .redirect (redirect),
        .bubbles  (bubble_cnt)
    );

    always_comb begin
        case (policy)
            POLICY_TABLE: pred_taken = hint;
            default:      pred_taken = lk_disp[DISP_W-1];
        endcase
    end

    // R5
    busy_guess_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && lk_dyn) |-> !pred_taken);

    // R6
    redirect_cnt_chk: assert property (@(posedge clk) disable iff (rst)
        redirect |-> (bubble_cnt != '0 && bubble_cnt <= CNT_W'(PENALTY)));

endmodule

// File: tb/bdir_predictor_test.sv
`timescale 1ns/1ps
module bdir_predictor_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        clr_req = 1'b0;
    logic [31:0] lk_pc = '0;
    logic [20:0] lk_disp = '0;
    logic        lk_dyn = 1'b0;
    logic        upd_valid = 1'b0;
    logic [31:0] upd_pc = '0;
    logic        upd_taken = 1'b0;
    logic        res_valid = 1'b0;
    logic        res_mispredict = 1'b0;
    logic        pred_taken, pred2;
    logic        busy, busy2;
    logic        redirect, redirect2;
    logic [2:0]  bubble_cnt, bubble2;

    int n_tests = 0;
    int n_fail  = 0;
    int cycles  = 0;

    always #4 clk = ~clk;

    bdir_predictor uut (
        .clk(clk), .rst(rst), .clr_req(clr_req),
        .lk_pc(lk_pc), .lk_disp(lk_disp), .lk_dyn(lk_dyn), .pred_taken(pred_taken),
        .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken),
        .res_valid(res_valid), .res_mispredict(res_mispredict),
        .busy(busy), .redirect(redirect), .bubble_cnt(bubble_cnt)
    );

    bdir_predictor #(.IDX_W(12), .CTR_W(2)) uut2 (
        .clk(clk), .rst(rst), .clr_req(clr_req),
        .lk_pc(lk_pc), .lk_disp(lk_disp), .lk_dyn(lk_dyn), .pred_taken(pred2),
        .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken),
        .res_valid(res_valid), .res_mispredict(res_mispredict),
        .busy(busy2), .redirect(redirect2), .bubble_cnt(bubble2)
    );

    typedef enum int { K_PRED, K_PRED2, K_BUB, K_REDIR, K_BUSY } kind_e;
    typedef struct {
        kind_e kind;
        int    exp;
        string tag;
    } item_t;

    item_t sb[$];

    task automatic check(input string tag, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic expect_item(input kind_e k, input int e, input string tag);
        item_t it;
        it.kind = k; it.exp = e; it.tag = tag;
        sb.push_back(it);
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    // monitor: compare everything queued for this cycle
    always @(negedge clk) begin
        while (sb.size() > 0) begin
            item_t it;
            int act;
            it = sb.pop_front();
            case (it.kind)
                K_PRED:  act = int'(pred_taken);
                K_PRED2: act = int'(pred2);
                K_BUB:   act = int'(bubble_cnt);
                K_REDIR: act = int'(redirect);
                default: act = int'(busy);
            endcase
            check(it.tag, act, it.exp);
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 30000) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=<30000", cycles);
            summary();
        end
    end

    task automatic lookup(input logic [31:0] pc, input logic dyn, input logic [20:0] disp);
        lk_pc = pc; lk_dyn = dyn; lk_disp = disp;
    endtask

    initial begin
        int cnt1;
        int cnt2;
        int t;
        // reset state
        step(); step();
        expect_item(K_BUSY, 1, "R5 busy in reset");
        expect_item(K_REDIR, 0, "R6 no redirect in reset");
        expect_item(K_BUB, 0, "R6 bubbles zero in reset");
        rst = 1'b0;
        lookup(32'h0000_0014, 1'b1, 21'h0);
        cnt1 = 0; cnt2 = 0; t = 0;
        while ((busy || busy2) && t < 5000) begin
            @(negedge clk);
            if (busy)  cnt1++;
            if (busy2) cnt2++;
            if (t == 0) check("R5 table guess while busy", int'(pred_taken), 0);
            t++;
            @(posedge clk); #1;
            upd_valid = (t == 300);
            upd_pc    = 32'h0000_0014;
            upd_taken = 1'b1;
        end
        upd_valid = 1'b0;
        check("R5 busy cycles 1-bit", cnt1, 2048);
        check("R5 busy cycles 2-bit", cnt2, 4096);

        // update during busy was ignored
        lookup(32'h0000_0014, 1'b1, 21'h0);
        expect_item(K_PRED, 0, "R5 update during sweep ignored");
        step();

        // R1 static policy
        lookup(32'h0000_0100, 1'b0, 21'h10_0000);
        expect_item(K_PRED, 1, "R1 backward taken");
        step();
        lookup(32'h0000_0100, 1'b0, 21'h0F_FFFF);
        expect_item(K_PRED, 0, "R1 forward not taken");
        step();

        // R2 dynamic after clear
        lookup(32'h0000_0100, 1'b1, 21'h10_0000);
        expect_item(K_PRED, 0, "R2 cleared entry not taken");
        step();

        // R4 same-cycle update returns old value
        upd_valid = 1'b1; upd_pc = 32'h0000_0100; upd_taken = 1'b1;
        expect_item(K_PRED, 0, "R4 same-cycle old value");
        step();
        upd_valid = 1'b0;
        expect_item(K_PRED, 1, "R3 entry overwritten taken");
        step();
        lookup(32'h0000_0103, 1'b1, 21'h0);
        expect_item(K_PRED, 1, "R2 low pc bits ignored");
        step();
        lookup(32'h0000_2100, 1'b1, 21'h0);
        expect_item(K_PRED, 1, "R2 high pc bits ignored");
        step();
        lookup(32'h0000_0104, 1'b1, 21'h0);
        expect_item(K_PRED, 0, "R2 neighbour entry untouched");
        step();
        lookup(32'h0000_0100, 1'b0, 21'h0);
        expect_item(K_PRED, 0, "R1 static ignores table");
        step();
        lookup(32'h0000_0100, 1'b1, 21'h0);
        upd_valid = 1'b1; upd_pc = 32'h0000_0100; upd_taken = 1'b0;
        expect_item(K_PRED, 1, "R4 old value before clear write");
        step();
        upd_valid = 1'b0;
        expect_item(K_PRED, 0, "R3 entry overwritten not taken");
        step();

        // R6 mispredict penalty
        res_valid = 1'b1; res_mispredict = 1'b0;
        step();
        res_valid = 1'b0;
        expect_item(K_REDIR, 0, "R6 correct guess no redirect");
        step();
        res_valid = 1'b1; res_mispredict = 1'b1;
        expect_item(K_BUB, 0, "R6 bubbles before edge");
        step();
        res_valid = 1'b0; res_mispredict = 1'b0;
        for (int k = 4; k >= 1; k--) begin
            expect_item(K_BUB, k, "R6 bubble countdown");
            expect_item(K_REDIR, 1, "R6 redirect active");
            step();
        end
        expect_item(K_BUB, 0, "R6 bubbles done");
        expect_item(K_REDIR, 0, "R6 redirect ends");
        step();

        // R7 reload during redirect
        res_valid = 1'b1; res_mispredict = 1'b1;
        step();
        res_valid = 1'b0; res_mispredict = 1'b0;
        step();
        expect_item(K_BUB, 3, "R7 before second mispredict");
        res_valid = 1'b1; res_mispredict = 1'b1;
        step();
        res_valid = 1'b0; res_mispredict = 1'b0;
        expect_item(K_BUB, 4, "R7 reloaded");
        step();
        repeat (5) step();

        // R8 2-bit saturating counters on uut2
        begin
            int ctr;
            logic seq [10];
            seq = '{1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1};
            ctr = 0;
            lookup(32'h0000_4000, 1'b1, 21'h0);
            for (int i = 0; i < 10; i++) begin
                upd_valid = 1'b1; upd_pc = 32'h0000_4000; upd_taken = seq[i];
                expect_item(K_PRED2, (ctr >= 2) ? 1 : 0, "R8 counter guess before update");
                step();
                if (seq[i]) ctr = (ctr == 3) ? 3 : ctr + 1;
                else        ctr = (ctr == 0) ? 0 : ctr - 1;
            end
            upd_valid = 1'b0;
            expect_item(K_PRED2, (ctr >= 2) ? 1 : 0, "R8 counter final guess");
            step();
        end

        // R5 clear request
        upd_valid = 1'b1; upd_pc = 32'h0000_0200; upd_taken = 1'b1;
        step();
        upd_valid = 1'b0;
        lookup(32'h0000_0200, 1'b1, 21'h0);
        expect_item(K_PRED, 1, "R3 entry set before clear");
        step();
        clr_req = 1'b1;
        step();
        clr_req = 1'b0;
        expect_item(K_BUSY, 1, "R5 busy after clear request");
        expect_item(K_PRED, 0, "R5 table guess while clearing");
        step();
        t = 0;
        while (busy && t < 5000) begin
            step();
            t++;
        end
        check("R5 clear request sweep length", t + 1, 2048);
        expect_item(K_PRED, 0, "R5 entry zero after clear");
        step();
        step();
        summary();
    end

endmodule